// File: doc/BRIEF.md
# Three-Phase Centre-Aligned PWM Generator

This block produces three complementary pairs of gate-drive signals from one up/down time base. Each pair has a high-side and a low-side output, both active low, so a high level means the switch is off. The time base counts up from zero to the half-period limit and then back down again. Each pair's on-time is therefore centred in the period, and both of its switching edges move by the same amount when the duty value changes. A dead-time value pulls each edge inward, so every transition inside a pair has a guard gap of twice that value.

Software programs the unit through a small write/read register bus. Duty, half-period and dead-time writes go to shadow registers. The active copies reload at the start of each period, and in double-update mode they also reload at the midpoint. A one-cycle sync pulse marks every period start. Each pair can swap its two signals, and each side can be chopped by a divided clock. An external trip input forces all six outputs off at once, and they stay off until software clears the trip flag and the next period begins.

Top module: `tpwm_core`

## Requirements
- R1: With half-period P (the value 0 acts as 1), dead time D and duty d where 0 < d < P, a full period of 2P cycles starting at the sync pulse holds the high side on for 2*max(0, d-D) cycles and the low side on for 2*max(0, P-d-D) cycles. Outputs are active low, so on means the pin is 0.
- R2: A duty of 0 keeps the high side off and the low side on for the whole period. A duty of P or more keeps the high side on and the low side off for the whole period.
- R3: The two outputs of a pair are never on in the same cycle, and each edge is delayed inward by D cycles.
- R4: Control bit 1 selects double update. When it is set, a duty written during the first half takes effect in the second half of the same period. When it is clear, the new duty waits for the next period.
- R5: While the trip input is high, all six outputs are high in the same cycle, with no clock edge needed.
- R6: A trip sets a sticky trip flag (status bit 1), which drives the trip interrupt output. All outputs stay high until the flag is cleared by writing 1 to status bit 1 while the trip input is low and a period start has then passed.
- R7: The sync output and the sync interrupt give one one-cycle pulse in the first cycle of each period, which is one pulse per 2P cycles.
- R8: Status bit 0 reads 0 while the counter is in the rising half and 1 in the falling half.
- R9: Control bits 4:2 give pair crossover. When a pair's bit is set, its high-side and low-side signals are swapped.
- R10: Control bits 5 and 6 enable chopping of the high sides and the low sides. An on signal is then gated by a square wave that toggles every (div+1) cycles, where div is the 8-bit value at address 6. A chopped output that is on for a run of 2(div+1)*k cycles is on for half of that run.
- R11: After reset, and while control bit 0 (enable) is clear, all outputs are high and there is no sync pulse.
- R12: Register addresses: 0 control, 1 half-period, 2 dead time, 3 to 5 duty of pairs 0 to 2, 6 chop divider, 7 status. Read data is registered and returns the written value one cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Registered read data |
| trip_in | input | 1 | Asynchronous shutdown request, active high |
| pwm_h_n | output | 3 | High-side outputs, active low |
| pwm_l_n | output | 3 | Low-side outputs, active low |
| sync_o | output | 1 | Period-start pulse |
| irq_sync | output | 1 | Sync interrupt pulse |
| irq_trip | output | 1 | Trip interrupt level |

## Verification
The duty path is tried with random duties from zero to beyond the half-period, together with random dead times, half-periods and crossover masks. The on-cycle count of each output over one full period is then compared with the closed-form count. This separates correct centring from off-by-one edge errors, dead time applied on one side only, and swapped pairs. Directed patterns cover the cases that random values rarely hit. A duty rewritten in mid-period tells double update apart from single update. Chopped full-on runs show the divider rate. A single trip pulse shows the immediate forcing, the latch, and the release at the next period boundary.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;
  localparam int NCH = 3;

  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_PER   = 3'd1,
    RA_DEAD  = 3'd2,
    RA_DUTY0 = 3'd3,
    RA_DUTY1 = 3'd4,
    RA_DUTY2 = 3'd5,
    RA_CHOP  = 3'd6,
    RA_STAT  = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic           chop_lo;
    logic           chop_hi;
    logic [NCH-1:0] xover;
    logic           dbl;
    logic           en;
  } ctrl_t;
endpackage

// File: rtl/tpwm_timebase.sv
module tpwm_timebase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         dbl,
  input  logic [W-1:0] per,
  output logic [W-1:0] cnt,
  output logic         half,
  output logic         live,
  output logic         ld_start,
  output logic         ld_mid,
  output logic         sync_pre
);
  logic [W-1:0] lim;
  assign lim = per - 1'b1;

  always_comb begin
    ld_start = run && (!live || (half && cnt == '0));
    ld_mid   = run && live && dbl && !half && (cnt == lim);
    sync_pre = run && live && !half && (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      half <= 1'b0;
      live <= 1'b0;
    end else if (!live) begin
      live <= 1'b1;
    end else if (!half) begin
      if (cnt == lim) half <= 1'b1;
      else            cnt  <= cnt + 1'b1;
    end else begin
      if (cnt == '0)  half <= 1'b0;
      else            cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/tpwm_chan.sv
module tpwm_chan #(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] per,
  input  logic [W-1:0] duty,
  input  logic [W-1:0] dead,
  input  logic         xover,
  output logic         hi_on,
  output logic         lo_on
);
  logic [W:0] thr;
  logic [W:0] c_ext;
  logic       h;
  logic       l;

  always_comb begin
    thr   = {1'b0, per} - {1'b0, duty};
    c_ext = {1'b0, cnt};
    if (duty >= per) begin
      h = 1'b1;
      l = 1'b0;
    end else if (duty == '0) begin
      h = 1'b0;
      l = 1'b1;
    end else begin
      h = c_ext >= (thr + {1'b0, dead});
      l = (c_ext + {1'b0, dead}) < thr;
    end
    hi_on = xover ? l : h;
    lo_on = xover ? h : l;
  end
endmodule

// File: rtl/tpwm_chop.sv
module tpwm_chop #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] div,
  output logic          ph
);
  logic [CW-1:0] c;

  always_ff @(posedge clk) begin
    if (rst) begin
      c  <= '0;
      ph <= 1'b0;
    end else if (c >= div) begin
      c  <= '0;
      ph <= ~ph;
    end else begin
      c  <= c + 1'b1;
    end
  end
endmodule

// File: rtl/tpwm_core.sv
module tpwm_core #(
  parameter int W  = 16,
  parameter int CW = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_wr,
  input  logic [2:0]               bus_addr,
  input  logic [W-1:0]             bus_wdata,
  output logic [W-1:0]             bus_rdata,
  input  logic                     trip_in,
  output logic [tpwm_pkg::NCH-1:0] pwm_h_n,
  output logic [tpwm_pkg::NCH-1:0] pwm_l_n,
  output logic                     sync_o,
  output logic                     irq_sync,
  output logic                     irq_trip
);
  import tpwm_pkg::*;
  localparam int CTW = $bits(ctrl_t);

  ctrl_t                   ctrl_q;
  logic [W-1:0]            sh_per, sh_dead, a_per, a_dead;
  logic [NCH-1:0][W-1:0]   sh_duty, a_duty;
  logic [CW-1:0]           chop_div;
  logic                    trip_st, shut;
  logic [W-1:0]            cnt;
  logic                    half, live, ld_start, ld_mid, sync_pre, chop_ph;
  logic [NCH-1:0]          hi_on, lo_on, hi_g, lo_g;
  logic [NCH-1:0]          h_q, l_q;
  logic                    sync_q;
  logic                    pass;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      sh_per   <= '0;
      sh_dead  <= '0;
      sh_duty  <= '0;
      chop_div <= '0;
    end else if (bus_wr) begin
      case (reg_addr_e'(bus_addr))
        RA_CTRL:  ctrl_q     <= ctrl_t'(bus_wdata[CTW-1:0]);
        RA_PER:   sh_per     <= bus_wdata;
        RA_DEAD:  sh_dead    <= bus_wdata;
        RA_DUTY0: sh_duty[0] <= bus_wdata;
        RA_DUTY1: sh_duty[1] <= bus_wdata;
        RA_DUTY2: sh_duty[2] <= bus_wdata;
        RA_CHOP:  chop_div   <= bus_wdata[CW-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      trip_st <= 1'b0;
    else if (trip_in)
      trip_st <= 1'b1;
    else if (bus_wr && reg_addr_e'(bus_addr) == RA_STAT && bus_wdata[1])
      trip_st <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                       shut <= 1'b0;
    else if (trip_in)              shut <= 1'b1;
    else if (ld_start && !trip_st) shut <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_per  <= '0;
      a_dead <= '0;
      a_duty <= '0;
    end else if (ld_start) begin
      a_per  <= (sh_per == '0) ? W'(1) : sh_per;
      a_dead <= sh_dead;
      a_duty <= sh_duty;
    end else if (ld_mid) begin
      a_dead <= sh_dead;
      a_duty <= sh_duty;
    end
  end

  tpwm_timebase #(.W(W)) u_tb (
    .clk(clk), .rst(rst), .run(ctrl_q.en), .dbl(ctrl_q.dbl), .per(a_per),
    .cnt(cnt), .half(half), .live(live), .ld_start(ld_start),
    .ld_mid(ld_mid), .sync_pre(sync_pre)
  );

  tpwm_chop #(.CW(CW)) u_chop (
    .clk(clk), .rst(rst), .div(chop_div), .ph(chop_ph)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tpwm_chan #(.W(W)) u_ch (
      .cnt(cnt), .per(a_per), .duty(a_duty[g]), .dead(a_dead),
      .xover(ctrl_q.xover[g]), .hi_on(hi_on[g]), .lo_on(lo_on[g])
    );
    assign hi_g[g] = hi_on[g] & (~ctrl_q.chop_hi | chop_ph);
    assign lo_g[g] = lo_on[g] & (~ctrl_q.chop_lo | chop_ph);
  end

  assign pass = live & ~shut & ~trip_in;

  always_ff @(posedge clk) begin
    if (rst || !ctrl_q.en) begin
      h_q    <= '1;
      l_q    <= '1;
      sync_q <= 1'b0;
    end else begin
      h_q    <= ~(hi_g & {NCH{pass}});
      l_q    <= ~(lo_g & {NCH{pass}});
      sync_q <= sync_pre;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (reg_addr_e'(bus_addr))
        RA_CTRL:  bus_rdata <= {{(W-CTW){1'b0}}, ctrl_q};
        RA_PER:   bus_rdata <= sh_per;
        RA_DEAD:  bus_rdata <= sh_dead;
        RA_DUTY0: bus_rdata <= sh_duty[0];
        RA_DUTY1: bus_rdata <= sh_duty[1];
        RA_DUTY2: bus_rdata <= sh_duty[2];
        RA_CHOP:  bus_rdata <= {{(W-CW){1'b0}}, chop_div};
        default:  bus_rdata <= {{(W-2){1'b0}}, trip_st, half};
      endcase
    end
  end

  assign pwm_h_n  = h_q | {NCH{trip_in}};
  assign pwm_l_n  = l_q | {NCH{trip_in}};
  assign sync_o   = sync_q;
  assign irq_sync = sync_q;
  assign irq_trip = trip_st;
endmodule

// File: rtl/tpwm_checks.sv
module tpwm_checks #(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           trip_in,
  input logic [NCH-1:0] pwm_h_n,
  input logic [NCH-1:0] pwm_l_n,
  input logic           sync_o,
  input logic           irq_trip,
  input logic           shut
);
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
    ((~pwm_h_n) & (~pwm_l_n)) == '0);

  a_r5_trip_forces_off: assert property (@(posedge clk) disable iff (rst)
    trip_in |-> (&pwm_h_n && &pwm_l_n));

  a_r6_trip_flags_irq: assert property (@(posedge clk) disable iff (rst)
    trip_in |=> irq_trip);

  a_r6_shut_holds_off: assert property (@(posedge clk) disable iff (rst)
    shut |-> (&pwm_h_n && &pwm_l_n));

  a_r7_sync_one_cycle: assert property (@(posedge clk) disable iff (rst)
    sync_o |=> !sync_o);
endmodule

bind tpwm_core tpwm_checks #(.NCH(tpwm_pkg::NCH)) u_chk (
  .clk(clk), .rst(rst), .trip_in(trip_in), .pwm_h_n(pwm_h_n),
  .pwm_l_n(pwm_l_n), .sync_o(sync_o), .irq_trip(irq_trip), .shut(shut)
);

// File: tb/tpwm_core_bench.sv
`timescale 1ns/1ps
module tpwm_core_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_wr = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic         trip_in = 1'b0;
  logic [2:0]   pwm_h_n, pwm_l_n;
  logic         sync_o, irq_sync, irq_trip;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int hc[3];
  int lc[3];
  int sc, ic;

  always #2 clk = ~clk;

  tpwm_core #(.W(W)) u_tpwm_core (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trip_in(trip_in),
    .pwm_h_n(pwm_h_n), .pwm_l_n(pwm_l_n), .sync_o(sync_o),
    .irq_sync(irq_sync), .irq_trip(irq_trip)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_hi(int d, int dd, int p);
    if (d >= p) return 2 * p;
    if (d == 0) return 0;
    return (d > dd) ? 2 * (d - dd) : 0;
  endfunction

  function automatic int exp_lo(int d, int dd, int p);
    if (d >= p) return 0;
    if (d == 0) return 2 * p;
    return (p - d > dd) ? 2 * (p - d - dd) : 0;
  endfunction

  function automatic int ctrl_word(bit en, bit dbl, int xo, bit chh, bit chl);
    return int'(en) | (int'(dbl) << 1) | ((xo & 7) << 2) | (int'(chh) << 5) | (int'(chl) << 6);
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1;
    bus_addr = 3'(a);
    bus_wdata = W'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    bus_addr = 3'(a);
    @(negedge clk);
    d = int'(bus_rdata);
  endtask

  task automatic wait_sync();
    do @(negedge clk); while (!sync_o);
  endtask

  task automatic measure(input int p);
    wait_sync();
    for (int i = 0; i < 3; i++) begin hc[i] = 0; lc[i] = 0; end
    sc = 0; ic = 0;
    for (int k = 0; k < 2 * p; k++) begin
      if (k > 0) @(negedge clk);
      for (int i = 0; i < 3; i++) begin
        if (!pwm_h_n[i]) hc[i]++;
        if (!pwm_l_n[i]) lc[i]++;
      end
      if (sync_o) sc++;
      if (irq_sync) ic++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, first, second, p, dd, xo;
    int du[3];
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 reset h_n", int'(pwm_h_n), 7);
    check("R11 reset l_n", int'(pwm_l_n), 7);
    check("R11 reset sync", int'(sync_o), 0);
    check("R11 reset irq_trip", int'(irq_trip), 0);

    wr(1, 20); wr(2, 2); wr(3, 10); wr(4, 0); wr(5, 25);
    // R11 disabled: nothing switches on
    v = 0;
    repeat (50) begin
      @(negedge clk);
      if (pwm_h_n != 3'b111 || pwm_l_n != 3'b111 || sync_o) v++;
    end
    check("R11 disabled activity", v, 0);
    rd(1, v); check("R12 readback period", v, 20);
    rd(4, v); check("R12 readback duty1", v, 0);

    wr(0, ctrl_word(1, 0, 0, 0, 0));
    wait_sync();
    measure(20);
    check("R1 hi0", hc[0], 16);  check("R1 lo0", lc[0], 16);
    check("R2 hi1 duty0", hc[1], 0);  check("R2 lo1 duty0", lc[1], 40);
    check("R2 hi2 over", hc[2], 40);  check("R2 lo2 over", lc[2], 0);
    check("R7 sync count", sc, 1);
    check("R7 irq_sync count", ic, 1);

    // R1 R3 R9 random patterns
    for (int it = 0; it < 10; it++) begin
      p = 8 + 4 * int'($urandom_range(0, 3));
      dd = int'($urandom_range(0, 4));
      xo = int'($urandom_range(0, 7));
      for (int i = 0; i < 3; i++) du[i] = int'($urandom_range(0, p + 3));
      wr(0, ctrl_word(1, 0, xo, 0, 0));
      wr(1, p); wr(2, dd);
      wr(3, du[0]); wr(4, du[1]); wr(5, du[2]);
      wait_sync();
      measure(p);
      for (int i = 0; i < 3; i++) begin
        if (((xo >> i) & 1) != 0) begin
          check("R9 random crossed hi", hc[i], exp_lo(du[i], dd, p));
          check("R9 random crossed lo", lc[i], exp_hi(du[i], dd, p));
        end else begin
          check("R1 random hi", hc[i], exp_hi(du[i], dd, p));
          check("R3 random lo", lc[i], exp_lo(du[i], dd, p));
        end
      end
      check("R7 random sync", sc, 1);
    end

    // R9 directed crossover on pair 0 only
    wr(0, ctrl_word(1, 0, 1, 0, 0));
    wr(1, 20); wr(2, 1); wr(3, 5); wr(4, 10); wr(5, 10);
    wait_sync(); measure(20);
    check("R9 crossed hi0", hc[0], 28); check("R9 crossed lo0", lc[0], 8);
    check("R3 plain hi1", hc[1], 18);   check("R3 plain lo1", lc[1], 18);

    // R4 double update
    wr(0, ctrl_word(1, 1, 0, 0, 0)); wr(2, 0); wr(3, 10);
    wait_sync(); wait_sync();
    first = 0; second = 0;
    for (int k = 0; k < 40; k++) begin
      if (k > 0) @(negedge clk);
      if (!pwm_h_n[0]) begin if (k < 20) first++; else second++; end
      if (k == 0) begin bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = W'(4); end
      else bus_wr = 1'b0;
    end
    check("R4 double first half", first, 10);
    check("R4 double second half", second, 4);

    // R4 single update
    wr(0, ctrl_word(1, 0, 0, 0, 0)); wr(3, 10);
    wait_sync(); wait_sync();
    first = 0; second = 0;
    for (int k = 0; k < 40; k++) begin
      if (k > 0) @(negedge clk);
      if (!pwm_h_n[0]) begin if (k < 20) first++; else second++; end
      if (k == 0) begin bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = W'(4); end
      else bus_wr = 1'b0;
    end
    check("R4 single first half", first, 10);
    check("R4 single second half", second, 10);
    measure(20);
    check("R4 single next period", hc[0], 8);

    // R8 half-period status
    wait_sync();
    bus_addr = 3'd7;
    for (int k = 1; k <= 25; k++) begin
      @(negedge clk);
      if (k == 1)  check("R8 rising half", int'(bus_rdata[0]), 0);
      if (k == 25) check("R8 falling half", int'(bus_rdata[0]), 1);
    end

    // R10 chopping
    wr(0, ctrl_word(1, 0, 0, 1, 1)); wr(6, 0);
    wr(3, 20); wr(4, 0); wr(5, 10);
    wait_sync(); measure(20);
    check("R10 chop hi full div0", hc[0], 20);
    check("R10 chop lo full div0", lc[1], 20);
    check("R10 chop hi mid div0", hc[2], 10);
    check("R10 chop lo mid div0", lc[2], 10);
    wr(6, 1);
    wait_sync(); measure(20);
    check("R10 chop hi full div1", hc[0], 20);
    check("R10 chop hi mid div1", hc[2], 10);

    // R5 R6 trip
    wr(0, ctrl_word(1, 0, 0, 0, 0)); wr(2, 2); wr(3, 10); wr(4, 10); wr(5, 10);
    wait_sync(); wait_sync();
    repeat (12) @(negedge clk);
    trip_in = 1'b1;
    #1;
    check("R5 trip immediate h_n", int'(pwm_h_n), 7);
    check("R5 trip immediate l_n", int'(pwm_l_n), 7);
    @(negedge clk);
    trip_in = 1'b0;
    check("R6 irq_trip set", int'(irq_trip), 1);
    v = 0;
    repeat (60) begin
      @(negedge clk);
      if (pwm_h_n != 3'b111 || pwm_l_n != 3'b111) v++;
    end
    check("R6 held off after trip", v, 0);
    rd(7, v); check("R6 status flag", (v >> 1) & 1, 1);
    wr(7, 2);
    rd(7, v); check("R6 flag cleared", (v >> 1) & 1, 0);
    check("R6 irq_trip cleared", int'(irq_trip), 0);
    wait_sync(); measure(20);
    check("R6 resumed hi0", hc[0], 16);
    check("R6 resumed lo0", lc[0], 16);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule